// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Detector with Lock Flag

This block compares a reference input against a feedback input, both single-bit signals sampled on a fast system clock. Only the rising edges of either input matter. From them it produces a pump-up request, a pump-down request and a lock flag. The two requests together encode a three-state charge-pump drive: pull up, pull down, or float.

A reference edge that comes first raises the up request. The feedback edge that follows clears it. A feedback edge that comes first raises the down request, and the next reference edge clears it. When the two inputs run at the same frequency, each pulse is as long as their phase gap. Under a frequency mismatch the faster side keeps its request active for most of the time. If the reference disappears, feedback edges hold the down request for as long as it is missing. The lock flag is high exactly while neither request is active.

Each input first passes through a synchroniser and then a rising-edge detector. The outputs come straight from a small state register.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the float state: `pump_up`=0, `pump_dn`=0 and `lock_flag`=1.
- R2: In the float state, a reference rising edge on its own sets `pump_up`. Further reference rising edges leave `pump_up` set.
- R3: In the float state, a feedback rising edge on its own sets `pump_dn`.
- R4: A feedback rising edge on its own ends an up pulse, and a reference rising edge on its own ends a down pulse. Either one returns the block to the float state.
- R5: Rising edges on both inputs in the same sampled cycle cancel, and the next state is float.
- R6: `pump_up` and `pump_dn` are never high together, and `lock_flag` is high exactly when both are low.
- R7: When an input is first sampled high at clock edge k after being low, the resulting output change appears after edge k+2 and not before.
- R8: Falling edges and duty cycle have no effect. Two inputs whose rising edges coincide but whose high times differ produce no pump activity.
- R9: With the reference held still, each feedback edge keeps `pump_dn` high continuously.
- R10: If the reference is faster than the feedback, `pump_up` is high more than half the time and `pump_dn` never is. The mirror case holds for a slower reference.
- R11: At equal frequency, the active request is high for exactly the lag in clock cycles in every period. A lagging feedback gives `pump_up` and a lagging reference gives `pump_dn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fbk_in | input | 1 | Feedback signal, asynchronous |
| pump_up | output | 1 | Pull-up request to the charge pump |
| pump_dn | output | 1 | Pull-down request to the charge pump |
| lock_flag | output | 1 | High while neither request is active |

## Verification
The hardest case to reach from the ports is two rising edges landing in the same sampled cycle. It needs both inputs to rise between the same pair of clock edges. The bench sets this up twice. The first time it raises both manual inputs at one negative edge. The second time it runs two generated waveforms with identical period and phase but different high times, so every edge coincides. Sustained mismatch is reached with period pairs whose beat pattern repeats within the measuring window, which makes the expected duty counts exact.

// File: rtl/pfd_pkg.sv
// Package: shared state encoding for the phase-frequency detector.
// Assumes: at most one pump request is active in any state.
package pfd_pkg;

    // Detector state; the float state is the only one that reports lock.
    typedef enum logic [1:0] {
        PD_FLOAT = 2'b00,
        PD_UP    = 2'b01,
        PD_DN    = 2'b10
    } pd_state_t;

    localparam int unsigned PD_CHANNELS = 2;
    localparam int unsigned PD_REF_IDX  = 0;
    localparam int unsigned PD_FBK_IDX  = 1;

endpackage

// File: rtl/pfd_sync.sv
// Module: pfd_sync
// Carries one asynchronous bit into the clk domain through a shift chain.
// Assumes: STAGES >= 2; synchronous active-low reset clears the chain.
module pfd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain;

    // Shift the raw input through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], d_async};
    end

    assign q_sync = chain[TOP];

endmodule

// File: rtl/pfd_edge.sv
// Module: pfd_edge
// Flags a synchronised signal going from low to high for one cycle.
// Assumes: input already in the clk domain; reset history is low.
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    logic prev;

    // Remember the previous sample for the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;

endmodule

// File: rtl/pfd_core.sv
// Module: pfd_core
// Three-state edge machine: a reference edge pushes toward UP, a feedback
// edge pushes toward DN, and coincident edges cancel into FLOAT.
// Assumes: rise inputs are single-cycle pulses in the clk domain.
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fbk_rise,
    output logic up_o,
    output logic dn_o,
    output logic lock_o
);

    pd_state_t state, state_nx;

    // Next-state selection from the two edge pulses.
    always_comb begin
        state_nx = state;
        if (ref_rise && fbk_rise) begin
            state_nx = PD_FLOAT;
        end else if (ref_rise) begin
            case (state)
                PD_DN:   state_nx = PD_FLOAT;
                default: state_nx = PD_UP;
            endcase
        end else if (fbk_rise) begin
            case (state)
                PD_UP:   state_nx = PD_FLOAT;
                default: state_nx = PD_DN;
            endcase
        end
    end

    // State register with synchronous reset to the float state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_FLOAT;
        else        state <= state_nx;
    end

    assign up_o   = (state == PD_UP);
    assign dn_o   = (state == PD_DN);
    assign lock_o = (state == PD_FLOAT);

    // R2
    ref_sets_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && ref_rise && !fbk_rise) |=> up_o);

    // R3
    fbk_sets_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && fbk_rise && !ref_rise) |=> dn_o);

    // R4
    up_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && fbk_rise && !ref_rise) |=> lock_o);

    // R4
    dn_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_o && ref_rise && !fbk_rise) |=> lock_o);

    // R5
    both_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && fbk_rise) |=> lock_o);

    // R6
    no_dual_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_o, dn_o}));

    // R9
    dn_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_o && !ref_rise) |=> dn_o);

endmodule

// File: rtl/pfd_lock_top.sv
// Module: pfd_lock_top
// Phase-frequency detector: synchronises both inputs, finds rising edges
// and drives up/down pump requests plus a lock flag.
// Assumes: inputs are slow relative to clk (at least a few cycles per level).
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fbk_in,
    output logic pump_up,
    output logic pump_dn,
    output logic lock_flag
);

    logic [PD_CHANNELS-1:0] raw, synced, rises;

    assign raw[PD_REF_IDX] = ref_in;
    assign raw[PD_FBK_IDX] = fbk_in;

    // One synchroniser and edge detector per input channel.
    for (genvar ch = 0; ch < PD_CHANNELS; ch++) begin : g_chan
        pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (raw[ch]),
            .q_sync  (synced[ch])
        );
        pfd_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   (synced[ch]),
            .rise  (rises[ch])
        );
    end

    pfd_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (rises[PD_REF_IDX]),
        .fbk_rise (rises[PD_FBK_IDX]),
        .up_o     (pump_up),
        .dn_o     (pump_dn),
        .lock_o   (lock_flag)
    );

    // R6
    lock_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag == !(pump_up || pump_dn));

endmodule

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_i = 1'b0;
    logic fb_i = 1'b0;
    logic up, dn, lk;

    always #4 clk = ~clk;   // 125 MHz

    pfd_lock_top u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_i), .fbk_in(fb_i),
        .pump_up(up), .pump_dn(dn), .lock_flag(lk)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit started = 0;
    string cur_req = "R1";

    // stimulus control
    bit gen_on = 0, man_ref = 0, man_fb = 0, ref_en = 1;
    int ref_per = 20, ref_hi = 10, ref_ph = 0;
    int fb_per = 20, fb_hi = 10, fb_ph = 0;
    int cyc = 0;

    // behavioural reference model: 0 float, 1 up, 2 down
    int rq[$];
    int fq[$];
    int mstate = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            rq = '{0, 0, 0};
            fq = '{0, 0, 0};
            mstate = 0;
        end else begin
            bit rr, fr;
            rr = (rq[1] == 1) && (rq[2] == 0);
            fr = (fq[1] == 1) && (fq[2] == 0);
            if (rr && fr)      mstate = 0;
            else if (rr)       mstate = (mstate == 2) ? 0 : 1;
            else if (fr)       mstate = (mstate == 1) ? 0 : 2;
            rq.push_front(int'(ref_i)); void'(rq.pop_back());
            fq.push_front(int'(fb_i));  void'(fq.pop_back());
        end
    end

    // compare every cycle, then drive the next input values
    always @(negedge clk) begin
        if (started) begin
            chk({cur_req, " model up"}, int'(up), int'(mstate == 1));
            chk({cur_req, " model dn"}, int'(dn), int'(mstate == 2));
            chk("R6 lock", int'(lk), int'(!(up || dn)));
            chk("R6 excl", int'(up && dn), 0);
        end
        if (gen_on) begin
            ref_i <= ref_en && (((cyc + ref_ph) % ref_per) < ref_hi);
            fb_i  <= ((cyc + fb_ph) % fb_per) < fb_hi;
        end else begin
            ref_i <= man_ref;
            fb_i  <= man_fb;
        end
        cyc++;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic look();
        @(negedge clk); #1;
    endtask

    int up_cnt, dn_cnt;
    task automatic measure(input int n);
        up_cnt = 0; dn_cnt = 0;
        repeat (n) begin
            look();
            up_cnt += int'(up);
            dn_cnt += int'(dn);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        tick(5);
        look();
        chk("R1 up", int'(up), 0);
        chk("R1 dn", int'(dn), 0);
        chk("R1 lock", int'(lk), 1);
        rst_n = 1'b1;
        tick(3);

        // R7: latency of first reference edge
        cur_req = "R7";
        @(posedge clk); man_ref = 1;
        look();          // driven here, sampled at edge k
        tick(2);         // edges k, k+1
        look();
        chk("R7 up before k+2", int'(up), 0);
        tick(1);         // edge k+2
        look();
        chk("R7 up after k+2", int'(up), 1);
        chk("R2 lock low", int'(lk), 0);

        cur_req = "R2";
        @(posedge clk); man_ref = 0; tick(4);
        man_ref = 1; tick(5); look();
        chk("R2 up held", int'(up), 1);

        cur_req = "R4";
        @(posedge clk); man_fb = 1; tick(5); look();
        chk("R4 up ended", int'(lk), 1);

        cur_req = "R3";
        @(posedge clk); man_fb = 0; tick(3);
        man_fb = 1; tick(5); look();
        chk("R3 dn set", int'(dn), 1);

        cur_req = "R4";
        @(posedge clk); man_ref = 0; tick(3);
        man_ref = 1; tick(5); look();
        chk("R4 dn ended", int'(lk), 1);

        cur_req = "R5";
        @(posedge clk); man_ref = 0; man_fb = 0; tick(4);
        man_ref = 1; man_fb = 1; tick(5); look();
        chk("R5 coincident stays float", int'(lk), 1);
        chk("R5 no up", int'(up), 0);
        @(posedge clk); man_ref = 0; man_fb = 0; tick(4);

        // generated waveforms
        cur_req = "R8";
        ref_per = 20; ref_hi = 3;  ref_ph = 0;
        fb_per  = 20; fb_hi  = 15; fb_ph  = 0;
        gen_on = 1; tick(100);
        measure(200);
        chk("R8 up count", up_cnt, 0);
        chk("R8 dn count", dn_cnt, 0);

        cur_req = "R11";
        ref_hi = 10; fb_hi = 10; fb_ph = 15;   // feedback lags by 5
        tick(100); measure(200);
        chk("R11 up width total", up_cnt, 50);
        chk("R11 dn zero", dn_cnt, 0);
        ref_ph = 13; fb_ph = 0;                // reference lags by 7
        tick(100); measure(200);
        chk("R11 dn width total", dn_cnt, 70);
        chk("R11 up zero", up_cnt, 0);

        cur_req = "R10";
        ref_per = 10; ref_hi = 5; ref_ph = 0;
        fb_per = 13; fb_hi = 6; fb_ph = 0;
        tick(200); measure(1300);
        chk("R10 fast ref dn", dn_cnt, 0);
        chk("R10 fast ref up majority", int'(up_cnt > 650), 1);
        ref_per = 13; ref_hi = 6; fb_per = 10; fb_hi = 5;
        tick(200); measure(1300);
        chk("R10 slow ref up", up_cnt, 0);
        chk("R10 slow ref dn majority", int'(dn_cnt > 650), 1);

        cur_req = "R9";
        ref_en = 0; fb_per = 16; fb_hi = 8;
        tick(100); measure(300);
        chk("R9 dn continuous", dn_cnt, 300);
        chk("R9 up zero", up_cnt, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule